// File: doc/BRIEF.md
# Synchronous Fault Escalation Unit

This unit stands between the sources of synchronous fault exceptions and the pending-state table of an exception controller. Each cycle it may receive one request to pend an exception, given as an exception number together with that exception's enable bit, its priority, and the processor's current execution priority. Lower priority values are more urgent, and the execution priority may be negative. The unit decides whether the requested exception is pended unchanged, replaced by a hard fault, or turned into a lockup.

Only exception numbers in the synchronous fault window are candidates for escalation. That window starts at the hard fault number, 3, and stops just below 14. A fault in this window cannot be taken immediately if it is disabled, or if its priority is not strictly more urgent than the execution priority. Such a fault is escalated: the hard fault is pended in its place, and a forced flag is set in the hard-fault status word. If escalation is needed while the execution priority is negative, no escalation is possible. The unit then pends nothing and raises a sticky lockup flag instead.

The pending table is held inside the unit, so repeated pends and clears can be seen at the ports. Each accepted pend that sets a bit which was clear produces a one-cycle notification.

Top module: `fault_escalate_unit`

## Requirements
- R1: While reset is asserted, and on the cycle after it, every pending bit, the whole status word, the lockup flag and the new-pend pulse are 0.
- R2: A valid request whose number is 1, 2, or from 14 up to NUM_EXC-1 sets its own pending bit one cycle later. Its enable bit and its priority have no effect.
- R3: A fault numbered 3 to 13 that is enabled and whose signed priority is strictly below the execution priority is pended as itself. The forced bit is not set.
- R4: A fault numbered 3 to 13 whose priority is greater than or equal to the execution priority, with the execution priority at 0 or above, pends exception 3 and not itself. It also sets status bit 30 (forced).
- R5: A disabled fault numbered 3 to 13 is escalated as in R4, even when its priority is more urgent than the execution priority.
- R6: When R4 or R5 would escalate but the execution priority is negative, the lockup flag is set. No pending bit changes, no new-pend pulse occurs, and the forced bit is not set.
- R7: Once set, the lockup flag stays at 1 until reset. Later requests are still processed normally.
- R8: Pending an exception whose bit is already set changes no pending bit and produces no new-pend pulse. A pend that sets a clear bit pulses the new-pend output for one cycle, and the pend-number output gives that number.
- R9: The status word is write-one-to-clear. Writing with bit 30 set clears the forced bit. Writing with bit 30 clear leaves it unchanged. A forced set in the same cycle wins over a clear.
- R10: The clear input resets one pending bit. A pend of the same number in the same cycle wins.
- R11: A request with number 0, or with a number of NUM_EXC or above, is ignored.
- R12: The escalation window includes 3 and 13 and excludes 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pend request strobe |
| req_num | input | EXC_W | Exception number to pend |
| req_enabled | input | 1 | Enable bit of the requested exception |
| req_prio | input | PRIO_W | Signed priority of the requested exception |
| exec_prio | input | PRIO_W | Signed current execution priority |
| clr_valid | input | 1 | Pending-clear strobe |
| clr_num | input | EXC_W | Exception number whose pending bit is cleared |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | STAT_W | Write-one-to-clear data for the status word |
| pend_vec | output | NUM_EXC | Pending bit per exception number |
| pend_new | output | 1 | One-cycle pulse when a pend set a clear bit |
| pend_num | output | EXC_W | Number of the most recent accepted pend |
| hf_status | output | STAT_W | Hard-fault status word, forced flag at bit 30 |
| lockup | output | 1 | Sticky lockup flag |

## Verification
Several properties are checked on every cycle: the reset state, that lockup never falls outside reset, that every escalation sets the forced bit and pends exception 3, that an escalation at negative execution priority raises lockup with no new pend, that a pulse of the new-pend output always matches a set bit, that a non-fault number reaches its own bit, and that a lone write-one clears the forced bit. Some behaviours can only be shown by the bench's scenarios. These are the exact choice between pending as itself and escalating at the equal-priority and window-edge points, that a repeated pend leaves the table untouched, the priority of set over clear in the table and in the status word, and that out-of-range numbers leave no trace.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam int HARD_NUM   = 3;
    localparam int WINDOW_END = 14;
    localparam int FORCED_POS = 30;

    typedef enum logic [1:0] {
        ACT_IGNORE   = 2'd0,
        ACT_AS_IS    = 2'd1,
        ACT_ESCALATE = 2'd2,
        ACT_LOCKUP   = 2'd3
    } fe_act_e;

    typedef struct packed {
        fe_act_e act;
        logic    set_pend;
        logic    set_forced;
        logic    set_lock;
    } fe_decision_t;

    function automatic fe_decision_t decode_act(input fe_act_e a);
        fe_decision_t d;
        d.act        = a;
        d.set_pend   = (a == ACT_AS_IS) || (a == ACT_ESCALATE);
        d.set_forced = (a == ACT_ESCALATE);
        d.set_lock   = (a == ACT_LOCKUP);
        return d;
    endfunction

endpackage

// File: rtl/fe_decide.sv
module fe_decide
    import fe_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int EXC_W   = 6,
    parameter int PRIO_W  = 10
) (
    input  logic                     req_valid,
    input  logic [EXC_W-1:0]         req_num,
    input  logic                     req_enabled,
    input  logic signed [PRIO_W-1:0] req_prio,
    input  logic signed [PRIO_W-1:0] exec_prio,
    output fe_decision_t             dec,
    output logic [EXC_W-1:0]         tgt_num
);

    localparam logic [EXC_W:0]   LIMIT  = (EXC_W+1)'(NUM_EXC);
    localparam logic [EXC_W-1:0] HARD_N = EXC_W'(HARD_NUM);
    localparam logic [EXC_W-1:0] WEND_N = EXC_W'(WINDOW_END);

    logic    in_range;
    logic    in_window;
    logic    blocked;
    fe_act_e act;

    assign in_range  = (req_num != '0) && ({1'b0, req_num} < LIMIT);
    assign in_window = (req_num >= HARD_N) && (req_num < WEND_N);
    assign blocked   = (req_prio >= exec_prio) || !req_enabled;

    always_comb begin
        act     = ACT_IGNORE;
        tgt_num = req_num;
        if (req_valid && in_range) begin
            if (in_window && blocked) begin
                if (exec_prio[PRIO_W-1]) begin
                    act = ACT_LOCKUP;
                end else begin
                    act     = ACT_ESCALATE;
                    tgt_num = HARD_N;
                end
            end else begin
                act = ACT_AS_IS;
            end
        end
    end

    assign dec = decode_act(act);

endmodule

// File: rtl/fe_pend_table.sv
module fe_pend_table #(
    parameter int NUM_EXC = 32,
    parameter int EXC_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_valid,
    input  logic [EXC_W-1:0]   set_num,
    input  logic               clr_valid,
    input  logic [EXC_W-1:0]   clr_num,
    output logic [NUM_EXC-1:0] pend_vec,
    output logic               pend_new,
    output logic [EXC_W-1:0]   pend_num
);

    logic [NUM_EXC-1:0] set_hit;

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_slot
        logic clr_hit;
        assign set_hit[i] = set_valid && (set_num == EXC_W'(i));
        assign clr_hit    = clr_valid && (clr_num == EXC_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_vec[i] <= 1'b0;
            end else if (set_hit[i]) begin
                pend_vec[i] <= 1'b1;
            end else if (clr_hit) begin
                pend_vec[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_new <= 1'b0;
            pend_num <= '0;
        end else begin
            pend_new <= |(set_hit & ~pend_vec);
            if (set_valid) begin
                pend_num <= set_num;
            end
        end
    end

endmodule

// File: rtl/fe_status.sv
module fe_status
    import fe_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_forced,
    input  logic              set_lock,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] status,
    output logic              lockup
);

    logic forced_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            forced_q <= 1'b0;
        end else if (set_forced) begin
            forced_q <= 1'b1;
        end else if (wr && wdata[FORCED_POS]) begin
            forced_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lockup <= 1'b0;
        end else if (set_lock) begin
            lockup <= 1'b1;
        end
    end

    always_comb begin
        status             = '0;
        status[FORCED_POS] = forced_q;
    end

endmodule

// File: rtl/fault_escalate_unit.sv
module fault_escalate_unit
    import fe_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int EXC_W   = 6,
    parameter int PRIO_W  = 10,
    parameter int STAT_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [EXC_W-1:0]         req_num,
    input  logic                     req_enabled,
    input  logic signed [PRIO_W-1:0] req_prio,
    input  logic signed [PRIO_W-1:0] exec_prio,
    input  logic                     clr_valid,
    input  logic [EXC_W-1:0]         clr_num,
    input  logic                     stat_wr,
    input  logic [STAT_W-1:0]        stat_wdata,
    output logic [NUM_EXC-1:0]       pend_vec,
    output logic                     pend_new,
    output logic [EXC_W-1:0]         pend_num,
    output logic [STAT_W-1:0]        hf_status,
    output logic                     lockup
);

    fe_decision_t     dec;
    logic [EXC_W-1:0] tgt_num;

    fe_decide #(
        .NUM_EXC (NUM_EXC),
        .EXC_W   (EXC_W),
        .PRIO_W  (PRIO_W)
    ) u_decide (
        .req_valid   (req_valid),
        .req_num     (req_num),
        .req_enabled (req_enabled),
        .req_prio    (req_prio),
        .exec_prio   (exec_prio),
        .dec         (dec),
        .tgt_num     (tgt_num)
    );

    fe_pend_table #(
        .NUM_EXC (NUM_EXC),
        .EXC_W   (EXC_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .set_valid (dec.set_pend),
        .set_num   (tgt_num),
        .clr_valid (clr_valid),
        .clr_num   (clr_num),
        .pend_vec  (pend_vec),
        .pend_new  (pend_new),
        .pend_num  (pend_num)
    );

    fe_status #(
        .STAT_W (STAT_W)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .set_forced (dec.set_forced),
        .set_lock   (dec.set_lock),
        .wr         (stat_wr),
        .wdata      (stat_wdata),
        .status     (hf_status),
        .lockup     (lockup)
    );

endmodule

// File: rtl/fe_checker.sv
module fe_checker
    import fe_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int EXC_W   = 6,
    parameter int PRIO_W  = 10,
    parameter int STAT_W  = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic [EXC_W-1:0]         req_num,
    input logic                     req_enabled,
    input logic signed [PRIO_W-1:0] req_prio,
    input logic signed [PRIO_W-1:0] exec_prio,
    input logic                     stat_wr,
    input logic [STAT_W-1:0]        stat_wdata,
    input logic [NUM_EXC-1:0]       pend_vec,
    input logic                     pend_new,
    input logic [EXC_W-1:0]         pend_num,
    input logic [STAT_W-1:0]        hf_status,
    input logic                     lockup
);

    logic             valid_num;
    logic             fault_num;
    logic             must_escalate;
    logic [EXC_W-1:0] last_num;

    assign valid_num     = (req_num != '0) && (int'(req_num) < NUM_EXC);
    assign fault_num     = (int'(req_num) >= HARD_NUM) && (int'(req_num) < WINDOW_END);
    assign must_escalate = req_valid && valid_num && fault_num &&
                           ((req_prio >= exec_prio) || !req_enabled);

    always_ff @(posedge clk) last_num <= req_num;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pend_vec == '0 && hf_status == '0 && !lockup && !pend_new)); // R1

    AST_NONFAULT_PENDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && valid_num && !fault_num) |=> ((pend_vec >> last_num) & 1) == 1); // R2

    AST_ESCALATE_FORCES: assert property (@(posedge clk) disable iff (rst)
        (must_escalate && !exec_prio[PRIO_W-1]) |=> (hf_status[FORCED_POS] && pend_vec[HARD_NUM])); // R4

    AST_LOCKUP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (must_escalate && exec_prio[PRIO_W-1]) |=> (lockup && !pend_new)); // R6

    AST_LOCKUP_STICKY: assert property (@(posedge clk) disable iff (rst)
        lockup |=> lockup); // R7

    AST_NEW_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        pend_new |-> ((pend_vec >> pend_num) & 1) == 1); // R8

    AST_STATUS_W1C: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_wdata[FORCED_POS] && !req_valid) |=> !hf_status[FORCED_POS]); // R9

endmodule

bind fault_escalate_unit fe_checker #(
    .NUM_EXC (NUM_EXC),
    .EXC_W   (EXC_W),
    .PRIO_W  (PRIO_W),
    .STAT_W  (STAT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_num     (req_num),
    .req_enabled (req_enabled),
    .req_prio    (req_prio),
    .exec_prio   (exec_prio),
    .stat_wr     (stat_wr),
    .stat_wdata  (stat_wdata),
    .pend_vec    (pend_vec),
    .pend_new    (pend_new),
    .pend_num    (pend_num),
    .hf_status   (hf_status),
    .lockup      (lockup)
);

// File: tb/sim_fault_escalate_unit.sv
`timescale 1ns/1ps
module sim_fault_escalate_unit;

    localparam int NUM_EXC = 32;
    localparam int EXC_W   = 6;
    localparam int PRIO_W  = 10;
    localparam int STAT_W  = 32;
    localparam int NVEC    = 14;

    // entry: {num[6], en[1], prio[10], exec[10], target[6] (0 = none), forced[1], lock[1]}
    localparam logic [34:0] VEC [NVEC] = '{
        {6'd16, 1'b0, 10'd200,  10'd0,    6'd16, 1'b0, 1'b0}, // R2 disabled interrupt still pends
        {6'd2,  1'b1, 10'h3FE,  10'h3FF,  6'd2,  1'b0, 1'b0}, // R2 number below window
        {6'd14, 1'b0, 10'd255,  10'd10,   6'd14, 1'b0, 1'b0}, // R12 first number past window
        {6'd5,  1'b1, 10'd10,   10'd20,   6'd5,  1'b0, 1'b0}, // R3 takeable fault
        {6'd5,  1'b1, 10'd20,   10'd20,   6'd3,  1'b1, 1'b0}, // R4 equal priority
        {6'd6,  1'b1, 10'd40,   10'd20,   6'd3,  1'b1, 1'b0}, // R4 lower urgency
        {6'd11, 1'b1, 10'd3,    10'd0,    6'd3,  1'b1, 1'b0}, // R4 execution priority zero
        {6'd4,  1'b0, 10'd0,    10'd100,  6'd3,  1'b1, 1'b0}, // R5 disabled fault
        {6'd13, 1'b0, 10'd5,    10'd256,  6'd3,  1'b1, 1'b0}, // R12 last window number
        {6'd3,  1'b1, 10'h3FF,  10'h3FF,  6'd0,  1'b0, 1'b1}, // R6 hard fault at negative priority
        {6'd7,  1'b1, 10'd50,   10'h3FF,  6'd0,  1'b0, 1'b1}, // R6
        {6'd9,  1'b1, 10'h3FE,  10'h3FF,  6'd9,  1'b0, 1'b0}, // R3 more urgent than negative
        {6'd0,  1'b1, 10'd0,    10'd100,  6'd0,  1'b0, 1'b0}, // R11 number zero
        {6'd40, 1'b1, 10'd0,    10'd100,  6'd0,  1'b0, 1'b0}  // R11 beyond table
    };

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     req_valid = 1'b0;
    logic [EXC_W-1:0]         req_num = '0;
    logic                     req_enabled = 1'b0;
    logic signed [PRIO_W-1:0] req_prio = '0;
    logic signed [PRIO_W-1:0] exec_prio = '0;
    logic                     clr_valid = 1'b0;
    logic [EXC_W-1:0]         clr_num = '0;
    logic                     stat_wr = 1'b0;
    logic [STAT_W-1:0]        stat_wdata = '0;
    logic [NUM_EXC-1:0]       pend_vec;
    logic                     pend_new;
    logic [EXC_W-1:0]         pend_num;
    logic [STAT_W-1:0]        hf_status;
    logic                     lockup;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fault_escalate_unit #(
        .NUM_EXC (NUM_EXC), .EXC_W (EXC_W), .PRIO_W (PRIO_W), .STAT_W (STAT_W)
    ) u0 (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_num (req_num),
        .req_enabled (req_enabled), .req_prio (req_prio), .exec_prio (exec_prio),
        .clr_valid (clr_valid), .clr_num (clr_num), .stat_wr (stat_wr),
        .stat_wdata (stat_wdata), .pend_vec (pend_vec), .pend_new (pend_new),
        .pend_num (pend_num), .hf_status (hf_status), .lockup (lockup)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        req_valid = 1'b0;
        clr_valid = 1'b0;
        stat_wr   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic set_req(input int num, input logic en,
                           input int prio, input int ex);
        req_valid   = 1'b1;
        req_num     = EXC_W'(num);
        req_enabled = en;
        req_prio    = PRIO_W'(prio);
        exec_prio   = PRIO_W'(ex);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 pend_vec", 64'(pend_vec), 0);
        chk("R1 status", 64'(hf_status), 0);
        chk("R1 lockup", 64'(lockup), 0);
        chk("R1 pend_new", 64'(pend_new), 0);

        for (int k = 0; k < NVEC; k++) begin
            logic [34:0] v;
            logic [NUM_EXC-1:0] exp_vec;
            v = VEC[k];
            do_reset();
            set_req(int'(v[34:29]), v[28], int'($signed(v[27:18])), int'($signed(v[17:8])));
            tick();
            exp_vec = (v[7:2] != 0) ? (NUM_EXC'(1) << v[7:2]) : '0;
            chk($sformatf("vector %0d pend_vec (R2-R6 R11 R12)", k), 64'(pend_vec), 64'(exp_vec));
            chk($sformatf("vector %0d forced (R4 R5)", k), 64'(hf_status[30]), 64'(v[1]));
            chk($sformatf("vector %0d lockup (R6)", k), 64'(lockup), 64'(v[0]));
        end

        // R7: lockup sticks, later requests still handled
        do_reset();
        set_req(7, 1'b1, 50, -1);
        tick();
        set_req(16, 1'b1, 0, 0);
        tick();
        tick();
        chk("R7 lockup held", 64'(lockup), 1);
        chk("R7 later pend", 64'(pend_vec[16]), 1);

        // R8: repeated pend
        do_reset();
        set_req(16, 1'b1, 0, 0);
        tick();
        chk("R8 first pulse", 64'(pend_new), 1);
        chk("R8 pend_num", 64'(pend_num), 16);
        set_req(16, 1'b1, 0, 0);
        tick();
        chk("R8 repeat no pulse", 64'(pend_new), 0);
        chk("R8 repeat vec", 64'(pend_vec), 64'(NUM_EXC'(1) << 16));
        set_req(5, 1'b0, 0, 100);
        tick();
        chk("R8 first escalation pulse", 64'(pend_new), 1);

        // R9: write-one-to-clear
        stat_wr = 1'b1; stat_wdata = 32'hBFFF_FFFF;
        tick();
        chk("R9 zero bit keeps forced", 64'(hf_status[30]), 1);
        stat_wr = 1'b1; stat_wdata = 32'h4000_0000;
        tick();
        chk("R9 clear forced", 64'(hf_status[30]), 0);
        set_req(6, 1'b0, 0, 100);
        stat_wr = 1'b1; stat_wdata = 32'h4000_0000;
        tick();
        chk("R9 set wins over clear", 64'(hf_status[30]), 1);
        chk("R8 hard fault already pending no pulse", 64'(pend_new), 0);

        // R10: clear input
        clr_valid = 1'b1; clr_num = 6'd16;
        tick();
        chk("R10 clear", 64'(pend_vec[16]), 0);
        set_req(16, 1'b1, 0, 0);
        clr_valid = 1'b1; clr_num = 6'd16;
        tick();
        chk("R10 set wins over clear", 64'(pend_vec[16]), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule